// File: doc/BRIEF.md
# Unified Issue-and-Retire Instruction Queue

This block is a circular queue that holds every in-flight instruction of an out-of-order core, from the moment decode places it in the window until its result is written to the architectural register file. The same storage is the issue window and the in-order retirement buffer. Decode writes a new entry at the tail. Each cycle a selector offers the oldest entry whose operands are both available. Functional units return results into the entry named by its tag. A later instruction can read those results through a bypass lookup before they retire. Entries leave from the head only, in program order.

Speculation is handled inside the queue. When a branch writes back with its mispredict flag set, every entry younger than the branch is discarded. The tail is pulled back to the slot just after the branch, and a redirect pulse with the branch tag is raised for fetch. A fault is not reported when the instruction completes. It is reported when that entry reaches the head: no register write happens, the fault tag is presented, and the whole window is cleared.

Top module: `ruu_queue`

## Requirements
- R1: After synchronous reset the queue is empty. `alloc_ready` is 1, `alloc_tag` is 0, and `issue_valid`, `rf_we`, `exc_valid` and `flush_valid` are 0.
- R2: Each accepted allocation takes the slot shown on `alloc_tag`. Tags advance by one per allocation and wrap from DEPTH-1 to 0. `alloc_ready` is 0 while DEPTH entries are held.
- R3: `issue_valid` offers the oldest entry, counted from the head, that is valid, not yet issued, and has both sources ready. An entry is offered one time only, in the cycle after it becomes eligible.
- R4: A writeback with tag T marks ready every held source whose producer tag is T. A consumer that was waiting only on T is offered for issue in the next cycle.
- R5: `byp_hit` is 1 and `byp_value` carries the result when `byp_tag` names a held entry that has completed, or that receives a writeback in the same cycle. The writeback value is the one used in that case.
- R6: When the head entry has completed without a fault, `rf_we` is 1 with its destination and result in the same cycle. A completed younger entry never retires before an older entry that has not completed.
- R7: A writeback with the mispredict flag raises `flush_valid` with `flush_tag` equal to the branch tag, and holds `alloc_ready` and `issue_valid` at 0 for that cycle. Younger entries are never issued or retired. The next allocation takes slot branch+1. The branch itself retires normally.
- R8: When a faulting entry reaches the head, `exc_valid` is 1 with `exc_tag` equal to its slot, `rf_we` stays 0, and `alloc_ready` is 0. In the next cycle the queue is empty, and the next allocation takes the slot after the faulting one.
- R9: A source whose producer entry has already completed, or completes in the allocation cycle, is marked ready when the consumer is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Decode offers a new instruction |
| alloc_dest | input | REG_W | Destination architectural register |
| alloc_src1_tag | input | TAG_W | Producer slot of first operand |
| alloc_src1_rdy | input | 1 | First operand already available |
| alloc_src2_tag | input | TAG_W | Producer slot of second operand |
| alloc_src2_rdy | input | 1 | Second operand already available |
| alloc_ready | output | 1 | Queue accepts an allocation this cycle |
| alloc_tag | output | TAG_W | Slot the offered instruction will occupy |
| issue_valid | output | 1 | An entry is sent to execution |
| issue_tag | output | TAG_W | Slot of issued entry |
| issue_dest | output | REG_W | Destination of issued entry |
| wb_valid | input | 1 | A result returns |
| wb_tag | input | TAG_W | Slot the result belongs to |
| wb_value | input | DATA_W | Result value |
| wb_mispredict | input | 1 | Returning branch was mispredicted |
| wb_fault | input | 1 | Returning instruction faulted |
| flush_valid | output | 1 | Redirect fetch; younger entries dropped |
| flush_tag | output | TAG_W | Slot of the mispredicted branch |
| byp_tag | input | TAG_W | Slot looked up for operand bypass |
| byp_hit | output | 1 | Bypass value is available |
| byp_value | output | DATA_W | Bypassed result |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | REG_W | Register file write address |
| rf_wdata | output | DATA_W | Register file write data |
| exc_valid | output | 1 | Precise fault reported at retirement |
| exc_tag | output | TAG_W | Slot of the faulting instruction |

## Verification
A stale ready bit, a lost issued flag or a wrong age comparison shows up within one cycle. The result is a second or missing `issue_valid`, or an entry issued out of age order. A head or count error shows as `rf_we` firing for the wrong destination, firing early, or firing at all after a flush. Squash faults can hide until a discarded entry would have issued or retired, so the bench checks both in the cycle after the redirect, and also checks the tag given to the next allocation. A fault-clear error shows one cycle after `exc_valid`, when a completed younger result would otherwise be written.

// File: rtl/ruu_pkg.sv
package ruu_pkg;

    localparam int RUU_DEPTH = 8;
    localparam int TAG_W     = $clog2(RUU_DEPTH);
    localparam int CNT_W     = TAG_W + 1;
    localparam int DATA_W    = 16;
    localparam int REG_W     = 4;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [REG_W-1:0]  reg_t;

    typedef struct packed {
        tag_t tag;
        logic rdy;
    } src_t;

    typedef struct packed {
        logic  valid;
        logic  issued;
        logic  done;
        logic  mispred;
        logic  fault;
        reg_t  dest;
        src_t  s1;
        src_t  s2;
        data_t value;
    } ruu_entry_t;

    // Distance of a slot from the head; ring depth is a power of two.
    function automatic tag_t age_of(tag_t slot, tag_t head);
        return slot - head;
    endfunction

    // Source is usable now if decode says so or its producer has a result.
    function automatic logic src_wake(src_t s, tag_t wtag, logic wlive);
        return s.rdy | (wlive & (s.tag == wtag));
    endfunction

endpackage

// File: rtl/ruu_ptr_ctl.sv
module ruu_ptr_ctl #(
    parameter int DEPTH = 8,
    parameter int TW    = $clog2(DEPTH),
    parameter int CW    = TW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_en,
    input  logic          retire_en,
    input  logic          squash_en,
    input  logic [TW-1:0] squash_tag,
    input  logic          clear_en,
    output logic [TW-1:0] head,
    output logic [TW-1:0] tail,
    output logic [CW-1:0] count,
    output logic          full
);

    logic [TW-1:0] sq_age;

    assign sq_age = squash_tag - head;
    assign full   = (count == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (clear_en) begin
            head  <= head + 1'b1;
            tail  <= head + 1'b1;
            count <= '0;
        end else begin
            if (retire_en) head <= head + 1'b1;
            if (squash_en) begin
                tail  <= squash_tag + 1'b1;
                count <= CW'(sq_age) + CW'(1) - CW'(retire_en);
            end else begin
                if (alloc_en) tail <= tail + 1'b1;
                count <= count + CW'(alloc_en) - CW'(retire_en);
            end
        end
    end

endmodule

// File: rtl/ruu_oldest_pick.sv
module ruu_oldest_pick #(
    parameter int N  = 8,
    parameter int TW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [TW-1:0] base,
    output logic          found,
    output logic [TW-1:0] pick
);

    logic [TW-1:0] idx;

    // Rotating scan starting at the head: first hit is the oldest.
    always_comb begin
        found = 1'b0;
        pick  = base;
        idx   = base;
        for (int k = 0; k < N; k++) begin
            idx = base + TW'(k);
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end

endmodule

// File: rtl/ruu_slot.sv
module ruu_slot
    import ruu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       kill,
    input  logic       alloc_en,
    input  ruu_entry_t alloc_ent,
    input  logic       issue_en,
    input  logic       wb_hit,
    input  data_t      wb_value,
    input  logic       wb_mp,
    input  logic       wb_fault,
    input  logic       wake_en,
    input  tag_t       wake_tag,
    output ruu_entry_t ent
);

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            ent <= '0;
        end else if (alloc_en) begin
            ent <= alloc_ent;
        end else if (ent.valid) begin
            if (issue_en) ent.issued <= 1'b1;
            if (wb_hit) begin
                ent.done    <= 1'b1;
                ent.value   <= wb_value;
                ent.mispred <= wb_mp;
                ent.fault   <= wb_fault;
            end
            if (wake_en && (ent.s1.tag == wake_tag)) ent.s1.rdy <= 1'b1;
            if (wake_en && (ent.s2.tag == wake_tag)) ent.s2.rdy <= 1'b1;
        end
    end

endmodule

// File: rtl/ruu_queue.sv
module ruu_queue
    import ruu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [REG_W-1:0]  alloc_dest,
    input  logic [TAG_W-1:0]  alloc_src1_tag,
    input  logic              alloc_src1_rdy,
    input  logic [TAG_W-1:0]  alloc_src2_tag,
    input  logic              alloc_src2_rdy,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    output logic              issue_valid,
    output logic [TAG_W-1:0]  issue_tag,
    output logic [REG_W-1:0]  issue_dest,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_mispredict,
    input  logic              wb_fault,
    output logic              flush_valid,
    output logic [TAG_W-1:0]  flush_tag,
    input  logic [TAG_W-1:0]  byp_tag,
    output logic              byp_hit,
    output logic [DATA_W-1:0] byp_value,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              exc_valid,
    output logic [TAG_W-1:0]  exc_tag
);

    ruu_entry_t           ents [RUU_DEPTH];
    ruu_entry_t           head_ent;
    ruu_entry_t           wb_ent;
    ruu_entry_t           byp_ent;
    ruu_entry_t           new_ent;
    tag_t                 head;
    tag_t                 tail;
    logic [CNT_W-1:0]     cnt;
    logic                 full;
    logic                 wb_live;
    logic                 squash_now;
    logic                 retire_now;
    logic                 fault_now;
    logic                 do_alloc;
    logic [RUU_DEPTH-1:0] rdy_vec;
    logic                 pick_found;
    tag_t                 pick_tag;
    src_t                 s1_in;
    src_t                 s2_in;

    assign head_ent = ents[head];
    assign wb_ent   = ents[wb_tag];
    assign byp_ent  = ents[byp_tag];

    // Writebacks aimed at discarded slots are dropped.
    assign wb_live    = wb_valid & wb_ent.valid;
    assign squash_now = wb_live & wb_mispredict;
    assign retire_now = head_ent.valid & head_ent.done;
    assign fault_now  = retire_now & head_ent.fault;

    assign alloc_ready = !full && !squash_now && !fault_now;
    assign alloc_tag   = tail;
    assign do_alloc    = alloc_valid & alloc_ready;

    // Operand readiness at allocation: decode flag, completed producer,
    // or a producer completing this very cycle.
    always_comb begin
        s1_in.tag = alloc_src1_tag;
        s1_in.rdy = alloc_src1_rdy
                  | (ents[alloc_src1_tag].valid & ents[alloc_src1_tag].done);
        s1_in.rdy = src_wake(s1_in, wb_tag, wb_live);
        s2_in.tag = alloc_src2_tag;
        s2_in.rdy = alloc_src2_rdy
                  | (ents[alloc_src2_tag].valid & ents[alloc_src2_tag].done);
        s2_in.rdy = src_wake(s2_in, wb_tag, wb_live);
        new_ent         = '0;
        new_ent.valid   = 1'b1;
        new_ent.dest    = alloc_dest;
        new_ent.s1      = s1_in;
        new_ent.s2      = s2_in;
    end

    ruu_ptr_ctl #(
        .DEPTH (RUU_DEPTH),
        .TW    (TAG_W),
        .CW    (CNT_W)
    ) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (do_alloc),
        .retire_en  (retire_now),
        .squash_en  (squash_now),
        .squash_tag (wb_tag),
        .clear_en   (fault_now),
        .head       (head),
        .tail       (tail),
        .count      (cnt),
        .full       (full)
    );

    ruu_oldest_pick #(
        .N  (RUU_DEPTH),
        .TW (TAG_W)
    ) u_pick (
        .req   (rdy_vec),
        .base  (head),
        .found (pick_found),
        .pick  (pick_tag)
    );

    assign issue_valid = pick_found && !squash_now && !fault_now;
    assign issue_tag   = pick_tag;
    assign issue_dest  = ents[pick_tag].dest;

    for (genvar i = 0; i < RUU_DEPTH; i++) begin : g_slot
        localparam tag_t MY_TAG = tag_t'(i);
        logic kill_i;

        assign kill_i = (retire_now && (head == MY_TAG))
                      || fault_now
                      || (squash_now && (age_of(MY_TAG, head) > age_of(wb_tag, head)));

        assign rdy_vec[i] = ents[i].valid && !ents[i].issued
                          && ents[i].s1.rdy && ents[i].s2.rdy;

        ruu_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .kill      (kill_i),
            .alloc_en  (do_alloc && (tail == MY_TAG)),
            .alloc_ent (new_ent),
            .issue_en  (issue_valid && (issue_tag == MY_TAG)),
            .wb_hit    (wb_live && (wb_tag == MY_TAG)),
            .wb_value  (wb_value),
            .wb_mp     (wb_mispredict),
            .wb_fault  (wb_fault),
            .wake_en   (wb_live),
            .wake_tag  (wb_tag),
            .ent       (ents[i])
        );
    end

    assign flush_valid = squash_now;
    assign flush_tag   = wb_tag;

    always_comb begin
        byp_hit   = 1'b0;
        byp_value = byp_ent.value;
        if (wb_live && (wb_tag == byp_tag)) begin
            byp_hit   = 1'b1;
            byp_value = wb_value;
        end else if (byp_ent.valid && byp_ent.done) begin
            byp_hit   = 1'b1;
        end
    end

    assign rf_we     = retire_now & !head_ent.fault;
    assign rf_waddr  = head_ent.dest;
    assign rf_wdata  = head_ent.value;
    assign exc_valid = fault_now;
    assign exc_tag   = head;

endmodule

// File: rtl/ruu_queue_chk.sv
module ruu_queue_chk
    import ruu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             alloc_ready,
    input logic             issue_valid,
    input tag_t             issue_tag,
    input logic             flush_valid,
    input logic             rf_we,
    input logic             exc_valid,
    input tag_t             head,
    input logic [CNT_W-1:0] cnt
);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cnt == '0) && !issue_valid && !rf_we);  // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(RUU_DEPTH));  // R2

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_W'(RUU_DEPTH)) |-> !alloc_ready);  // R2

    AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> !(issue_valid && (issue_tag == $past(issue_tag))));  // R3

    AST_HEAD_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (rf_we || exc_valid) |=> (head == $past(head) + 1'b1));  // R6

    AST_FLUSH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> !alloc_ready && !issue_valid);  // R7

    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> !rf_we);  // R8

    AST_FAULT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (cnt == '0));  // R8

endmodule

bind ruu_queue ruu_queue_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .alloc_ready (alloc_ready),
    .issue_valid (issue_valid),
    .issue_tag   (issue_tag),
    .flush_valid (flush_valid),
    .rf_we       (rf_we),
    .exc_valid   (exc_valid),
    .head        (head),
    .cnt         (cnt)
);

// File: tb/ruu_queue_tb.sv
module ruu_queue_tb_top;
    import ruu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 12;

    typedef struct packed {
        logic        av;
        logic [3:0]  dst;
        logic [2:0]  t1;
        logic        r1;
        logic [2:0]  t2;
        logic        r2;
        logic        wv;
        logic [2:0]  wt;
        logic [15:0] wd;
        logic        eiv;
        logic [2:0]  eit;
        logic        ewe;
        logic [3:0]  ewa;
        logic [15:0] ewd;
        logic [2:0]  eat;
    } vec_t;

    // One row per cycle: stimulus, then outputs expected in that cycle.
    localparam vec_t VECS [NVEC] = '{
        '{1'b1,4'd1,3'd0,1'b1,3'd0,1'b1, 1'b0,3'd0,16'h0000, 1'b0,3'd0, 1'b0,4'd0,16'h0000, 3'd0},
        '{1'b1,4'd2,3'd0,1'b0,3'd0,1'b1, 1'b0,3'd0,16'h0000, 1'b1,3'd0, 1'b0,4'd0,16'h0000, 3'd1},
        '{1'b1,4'd3,3'd0,1'b1,3'd0,1'b1, 1'b0,3'd0,16'h0000, 1'b0,3'd0, 1'b0,4'd0,16'h0000, 3'd2},
        '{1'b0,4'd0,3'd0,1'b0,3'd0,1'b0, 1'b0,3'd0,16'h0000, 1'b1,3'd2, 1'b0,4'd0,16'h0000, 3'd0},
        '{1'b0,4'd0,3'd0,1'b0,3'd0,1'b0, 1'b1,3'd2,16'h0033, 1'b0,3'd0, 1'b0,4'd0,16'h0000, 3'd0},
        '{1'b0,4'd0,3'd0,1'b0,3'd0,1'b0, 1'b1,3'd0,16'h0011, 1'b0,3'd0, 1'b0,4'd0,16'h0000, 3'd0},
        '{1'b0,4'd0,3'd0,1'b0,3'd0,1'b0, 1'b0,3'd0,16'h0000, 1'b1,3'd1, 1'b1,4'd1,16'h0011, 3'd0},
        '{1'b0,4'd0,3'd0,1'b0,3'd0,1'b0, 1'b0,3'd0,16'h0000, 1'b0,3'd0, 1'b0,4'd0,16'h0000, 3'd0},
        '{1'b0,4'd0,3'd0,1'b0,3'd0,1'b0, 1'b1,3'd1,16'h0022, 1'b0,3'd0, 1'b0,4'd0,16'h0000, 3'd0},
        '{1'b0,4'd0,3'd0,1'b0,3'd0,1'b0, 1'b0,3'd0,16'h0000, 1'b0,3'd0, 1'b1,4'd2,16'h0022, 3'd0},
        '{1'b0,4'd0,3'd0,1'b0,3'd0,1'b0, 1'b0,3'd0,16'h0000, 1'b0,3'd0, 1'b1,4'd3,16'h0033, 3'd0},
        '{1'b1,4'd4,3'd0,1'b1,3'd0,1'b1, 1'b0,3'd0,16'h0000, 1'b0,3'd0, 1'b0,4'd0,16'h0000, 3'd3}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        alloc_valid;
    reg_t        alloc_dest;
    tag_t        alloc_src1_tag;
    logic        alloc_src1_rdy;
    tag_t        alloc_src2_tag;
    logic        alloc_src2_rdy;
    logic        alloc_ready;
    tag_t        alloc_tag;
    logic        issue_valid;
    tag_t        issue_tag;
    reg_t        issue_dest;
    logic        wb_valid;
    tag_t        wb_tag;
    data_t       wb_value;
    logic        wb_mispredict;
    logic        wb_fault;
    logic        flush_valid;
    tag_t        flush_tag;
    tag_t        byp_tag;
    logic        byp_hit;
    data_t       byp_value;
    logic        rf_we;
    reg_t        rf_waddr;
    data_t       rf_wdata;
    logic        exc_valid;
    tag_t        exc_tag;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ruu_queue dut_i (
        .clk            (clk),
        .rst            (rst),
        .alloc_valid    (alloc_valid),
        .alloc_dest     (alloc_dest),
        .alloc_src1_tag (alloc_src1_tag),
        .alloc_src1_rdy (alloc_src1_rdy),
        .alloc_src2_tag (alloc_src2_tag),
        .alloc_src2_rdy (alloc_src2_rdy),
        .alloc_ready    (alloc_ready),
        .alloc_tag      (alloc_tag),
        .issue_valid    (issue_valid),
        .issue_tag      (issue_tag),
        .issue_dest     (issue_dest),
        .wb_valid       (wb_valid),
        .wb_tag         (wb_tag),
        .wb_value       (wb_value),
        .wb_mispredict  (wb_mispredict),
        .wb_fault       (wb_fault),
        .flush_valid    (flush_valid),
        .flush_tag      (flush_tag),
        .byp_tag        (byp_tag),
        .byp_hit        (byp_hit),
        .byp_value      (byp_value),
        .rf_we          (rf_we),
        .rf_waddr       (rf_waddr),
        .rf_wdata       (rf_wdata),
        .exc_valid      (exc_valid),
        .exc_tag        (exc_tag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid    = 1'b0;
        alloc_dest     = '0;
        alloc_src1_tag = '0;
        alloc_src1_rdy = 1'b0;
        alloc_src2_tag = '0;
        alloc_src2_rdy = 1'b0;
        wb_valid       = 1'b0;
        wb_tag         = '0;
        wb_value       = '0;
        wb_mispredict  = 1'b0;
        wb_fault       = 1'b0;
        byp_tag        = '0;
    endtask

    task automatic next_cycle();
        @(negedge clk);
        idle();
    endtask

    task automatic alloc(input reg_t d, input tag_t t1, input logic r1);
        alloc_valid    = 1'b1;
        alloc_dest     = d;
        alloc_src1_tag = t1;
        alloc_src1_rdy = r1;
        alloc_src2_tag = '0;
        alloc_src2_rdy = 1'b1;
    endtask

    task automatic wb(input tag_t t, input data_t v, input logic mp, input logic flt);
        wb_valid      = 1'b1;
        wb_tag        = t;
        wb_value      = v;
        wb_mispredict = mp;
        wb_fault      = flt;
    endtask

    task automatic check_reset_state();
        check("R1 alloc_ready", 32'(alloc_ready), 32'd1);
        check("R1 alloc_tag",   32'(alloc_tag),   32'd0);
        check("R1 issue_valid", 32'(issue_valid), 32'd0);
        check("R1 rf_we",       32'(rf_we),       32'd0);
        check("R1 exc_valid",   32'(exc_valid),   32'd0);
        check("R1 flush_valid", 32'(flush_valid), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check_reset_state();

        // Table walk: allocation, out-of-order issue and completion,
        // wakeup of a waiting consumer, in-order retirement.
        for (int n = 0; n < NVEC; n++) begin
            vec_t v;
            v = VECS[n];
            next_cycle();
            alloc_valid    = v.av;
            alloc_dest     = v.dst;
            alloc_src1_tag = v.t1;
            alloc_src1_rdy = v.r1;
            alloc_src2_tag = v.t2;
            alloc_src2_rdy = v.r2;
            wb_valid       = v.wv;
            wb_tag         = v.wt;
            wb_value       = v.wd;
            #1;
            check("R3/R4 issue_valid", 32'(issue_valid), 32'(v.eiv));
            if (v.eiv) check("R3/R4 issue_tag", 32'(issue_tag), 32'(v.eit));
            check("R6 rf_we", 32'(rf_we), 32'(v.ewe));
            if (v.ewe) begin
                check("R6 rf_waddr", 32'(rf_waddr), 32'(v.ewa));
                check("R6 rf_wdata", 32'(rf_wdata), 32'(v.ewd));
            end
            if (v.av) check("R2 alloc_tag", 32'(alloc_tag), 32'(v.eat));
        end

        // Speculative squash: slot 3 holds a branch, 4 and 5 are younger.
        next_cycle(); alloc(4'd5, 3'd0, 1'b1); #1;
        check("R3 issue oldest", 32'(issue_tag), 32'd3);
        check("R2 alloc_tag", 32'(alloc_tag), 32'd4);
        next_cycle(); alloc(4'd6, 3'd0, 1'b1); #1;
        check("R2 alloc_tag", 32'(alloc_tag), 32'd5);
        check("R3 issue_tag", 32'(issue_tag), 32'd4);
        next_cycle(); wb(3'd3, 16'h0005, 1'b1, 1'b0); #1;
        check("R7 flush_valid", 32'(flush_valid), 32'd1);
        check("R7 flush_tag", 32'(flush_tag), 32'd3);
        check("R7 alloc_ready", 32'(alloc_ready), 32'd0);
        check("R7 issue held", 32'(issue_valid), 32'd0);
        next_cycle(); alloc(4'd8, 3'd0, 1'b1); #1;
        check("R7 tail rewound", 32'(alloc_tag), 32'd4);
        check("R7 branch retires", 32'(rf_we), 32'd1);
        check("R7 branch dest", 32'(rf_waddr), 32'd4);
        check("R7 squashed not issued", 32'(issue_valid), 32'd0);
        next_cycle(); #1;
        check("R7 new entry issues", 32'(issue_tag), 32'd4);

        // Bypass from a same-cycle writeback, then from the entry.
        next_cycle(); wb(3'd4, 16'h0077, 1'b0, 1'b0); byp_tag = 3'd4; #1;
        check("R5 byp_hit same cycle", 32'(byp_hit), 32'd1);
        check("R5 byp_value same cycle", 32'(byp_value), 32'h77);
        next_cycle(); byp_tag = 3'd4; #1;
        check("R5 byp_hit stored", 32'(byp_hit), 32'd1);
        check("R5 byp_value stored", 32'(byp_value), 32'h77);
        check("R6 rf_wdata", 32'(rf_wdata), 32'h77);
        next_cycle(); byp_tag = 3'd4; alloc(4'd9, 3'd7, 1'b0); #1;
        check("R5 retired no hit", 32'(byp_hit), 32'd0);
        check("R2 alloc_tag", 32'(alloc_tag), 32'd5);

        // Ready at allocation from a completed producer.
        next_cycle(); alloc(4'd10, 3'd0, 1'b1); #1;
        check("R3 blocked entry not issued", 32'(issue_valid), 32'd0);
        next_cycle(); #1;
        check("R3 issue_tag", 32'(issue_tag), 32'd6);
        next_cycle(); wb(3'd6, 16'h0066, 1'b0, 1'b0); #1;
        next_cycle(); alloc(4'd11, 3'd6, 1'b0); #1;
        check("R6 younger waits", 32'(rf_we), 32'd0);
        check("R2 alloc_tag", 32'(alloc_tag), 32'd7);
        next_cycle(); #1;
        check("R9 issue_valid", 32'(issue_valid), 32'd1);
        check("R9 issue_tag", 32'(issue_tag), 32'd7);

        // Fault reported only at the head, then the window is cleared.
        next_cycle(); wb(3'd5, 16'h0000, 1'b0, 1'b1); #1;
        check("R8 not yet reported", 32'(exc_valid), 32'd0);
        next_cycle(); #1;
        check("R8 exc_valid", 32'(exc_valid), 32'd1);
        check("R8 exc_tag", 32'(exc_tag), 32'd5);
        check("R8 no rf write", 32'(rf_we), 32'd0);
        check("R8 alloc_ready", 32'(alloc_ready), 32'd0);
        next_cycle(); alloc(4'd12, 3'd0, 1'b1); #1;
        check("R8 cleared no write", 32'(rf_we), 32'd0);
        check("R8 cleared no issue", 32'(issue_valid), 32'd0);
        check("R8 alloc_ready", 32'(alloc_ready), 32'd1);
        check("R8 alloc_tag", 32'(alloc_tag), 32'd6);

        // Fill to capacity with wrap-around tags.
        for (int k = 1; k < RUU_DEPTH; k++) begin
            next_cycle(); alloc(4'd13, 3'd6, 1'b0); #1;
            check("R2 wrap tag", 32'(alloc_tag), 32'((6 + k) % RUU_DEPTH));
            check("R2 ready before full", 32'(alloc_ready), 32'd1);
        end
        next_cycle(); alloc(4'd13, 3'd6, 1'b0); #1;
        check("R2 full blocks", 32'(alloc_ready), 32'd0);

        // Reset from a full queue.
        next_cycle(); rst = 1'b1;
        next_cycle(); rst = 1'b0; #1;
        check_reset_state();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule